// File: doc/BRIEF.md
# Pipelined No-Wait Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous SRAM whose bus can switch between reads and writes on every clock without idle cycles. Each accepted command is registered on the rising clock edge. A read returns its data two accepted cycles later. A write takes its data from the data input two accepted cycles after the command. Because both directions share the same two-cycle delay, read data and write data never contend for the same bus cycle.

A command either loads a fresh external address or advances a 2-bit burst counter. An advance repeats the type of the previous command, whether that was a read, a write or a deselect. A static input picks the order of the low two address bits within a burst: interleaved or linear. Byte lanes are written selectively through active-low lane enables. A clock-hold input freezes the whole block. A sleep request parks the block with its outputs disabled. An asynchronous output enable gates the data output.

Top module: `nwsram_top`

## Requirements
- R1: The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. An accepted cycle with `load_n`=0 while not selected is a deselect, and `dout_en` is 0 two accepted cycles later.
- R2: A read command loaded or advanced at accepted edge n drives `dout` with that address's contents after accepted edge n+2. `dout_en` is 1 there if `oe_n`=0.
- R3: A write command at accepted edge n stores `din` as sampled at accepted edge n+2. Lane k (bits 9k+8..9k) is written only where `bw_n[k]`=0. With all lanes high the cycle is an abort: the burst position still advances and the memory is unchanged.
- R4: An accepted cycle with `load_n`=1 repeats the type of the previous accepted command. After reset that type is deselect.
- R5: With `burst_ilv`=1, beat b of a burst started at low bits s uses low bits s XOR b.
- R6: With `burst_ilv`=0, beat b uses low bits (s+b) mod 4. In both orders the upper address bits stay those of the loaded address.
- R7: While `suspend`=1, every synchronous input is ignored and all state, including `dout`, holds.
- R8: `oe_n`=1 forces `dout_en` to 0 within the same cycle, without waiting for a clock edge.
- R9: A cycle is accepted only if `sleep` was 0 at both of the two previous edges, and `dout_en` is 0 in those cycles. Inputs are therefore ignored from the second edge of a sleep request, and sampling resumes on the third edge after release.
- R10: A read returns the data of every write commanded before it, including a write issued in the immediately preceding cycle, merged lane by lane by that write's enables.
- R11: During and right after reset `dout_en` is 0, and the first advance after reset continues a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| suspend | input | 1 | Clock hold: 1 freezes all state |
| sel_a_n | input | 1 | Select term, active low |
| sel_b | input | 1 | Select term, active high |
| sel_c_n | input | 1 | Select term, active low |
| load_n | input | 1 | 0 loads a new address and command, 1 advances the burst |
| rd_nwr | input | 1 | 1 read, 0 write (on a load) |
| bw_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | External word address |
| burst_ilv | input | 1 | 1 interleaved burst order, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request |
| din | input | LANES*LANE_W | Late write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Output drive enable (0 means high impedance) |

## Verification
Two functions can land on the same clock edge: a write committing its late data, and the array lookup for a read of that same word issued one cycle after the write. The bench provokes this by alternating writes and reads every cycle over a four-word address window, with random lane enables that include the all-high abort pattern. Each returned word is judged against a reference memory that is updated in command order at the moment the write is issued. The result must therefore equal the merged new data, never the stale array contents.

// File: rtl/nwsram_pkg.sv
package nwsram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    localparam int BEAT_W = 2;

    // Low address bits for a given beat of a burst.
    function automatic logic [BEAT_W-1:0] beat_bits(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              ilv
    );
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/nwsram_burst.sv
module nwsram_burst
    import nwsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              load_n,
    input  logic              sel,
    input  logic              rd_nwr,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] beat_nx;
    op_e               last_q;

    always_comb begin
        beat_nx = beat_q + BEAT_W'(1);
        if (!load_n) begin
            cmd_addr = addr;
            if (sel) cmd_op = rd_nwr ? OP_RD : OP_WR;
            else     cmd_op = OP_IDLE;
        end else begin
            cmd_op   = last_q;
            cmd_addr = {base_q[ADDR_W-1:BEAT_W],
                        beat_bits(base_q[BEAT_W-1:0], beat_nx, ilv)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
            last_q <= OP_IDLE;
        end else if (adv) begin
            last_q <= cmd_op;
            if (!load_n) begin
                base_q <= addr;
                beat_q <= '0;
            end else begin
                beat_q <= beat_nx;
            end
        end
    end

endmodule

// File: rtl/nwsram_doze.sv
module nwsram_doze #(
    parameter int GUARD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep,
    output logic doze
);

    logic [GUARD-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[GUARD-2:0], sleep};
    end

    assign doze = |hist_q;

endmodule

// File: rtl/nwsram_array.sv
module nwsram_array #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    commit,
    input  logic                    wr_pend,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        wlane_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] raw;
    logic              hit;

    always_ff @(posedge clk) begin
        if (commit && wr_pend) begin
            for (int l = 0; l < LANES; l++) begin
                if (!wlane_n[l]) mem_q[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    assign raw = mem_q[raddr];
    assign hit = wr_pend && (waddr == raddr);

    // Write committing this edge is forwarded into the read lookup.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rdata[g*LANE_W +: LANE_W] = (hit && !wlane_n[g])
                                         ? wdata[g*LANE_W +: LANE_W]
                                         : raw[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/nwsram_top.sv
module nwsram_top
    import nwsram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    suspend,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    load_n,
    input  logic                    rd_nwr,
    input  logic [LANES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    burst_ilv,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  bw_n;
    } slot_t;

    localparam slot_t SLOT_RST = '{op: OP_IDLE, addr: '0, bw_n: '1};

    logic              doze;
    logic              adv;
    logic              sel;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    slot_t             s1_q, s2_q;
    logic [DATA_W-1:0] rd_merged;
    logic [DATA_W-1:0] s2_data_q;
    logic [DATA_W-1:0] q_data;
    logic              q_live;
    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;

    assign sel = !sel_a_n && sel_b && !sel_c_n;
    assign adv = !suspend && !doze;

    nwsram_doze #(.GUARD(2)) u_doze (
        .clk   (clk),
        .rst   (rst),
        .sleep (sleep),
        .doze  (doze)
    );

    nwsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .load_n   (load_n),
        .sel      (sel),
        .rd_nwr   (rd_nwr),
        .ilv      (burst_ilv),
        .addr     (addr),
        .cmd_op   (cmd_op),
        .cmd_addr (cmd_addr)
    );

    nwsram_array #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .commit  (adv),
        .wr_pend (s2_q.op == OP_WR),
        .waddr   (s2_q.addr),
        .wlane_n (s2_q.bw_n),
        .wdata   (din),
        .raddr   (s1_q.addr),
        .rdata   (rd_merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q      <= SLOT_RST;
            s2_q      <= SLOT_RST;
            s2_data_q <= '0;
            q_data    <= '0;
            q_live    <= 1'b0;
        end else if (adv) begin
            s1_q      <= '{op: cmd_op, addr: cmd_addr, bw_n: bw_n};
            s2_q      <= s1_q;
            s2_data_q <= rd_merged;
            q_data    <= s2_data_q;
            q_live    <= (s2_q.op == OP_RD);
        end
    end

    assign s1_op   = s1_q.op;
    assign s1_addr = s1_q.addr;
    assign dout    = q_data;
    assign dout_en = q_live && !oe_n && !doze;

endmodule

// File: rtl/nwsram_checker.sv
module nwsram_checker
    import nwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              adv,
    input logic              load_n,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              burst_ilv,
    input logic              sleep,
    input logic              dout_en,
    input logic              q_live,
    input op_e               s1_op,
    input logic [ADDR_W-1:0] s1_addr,
    input logic [DATA_W-1:0] dout
);

    // R1: an unselected load registers a deselect
    a_r1_deselect: assert property (@(posedge clk) disable iff (rst)
        (adv && !load_n && !(!sel_a_n && sel_b && !sel_c_n)) |=> (s1_op == OP_IDLE))
        else $error("a_r1_deselect");

    // R4: an advance repeats the previous command type
    a_r4_continue: assert property (@(posedge clk) disable iff (rst)
        (adv && load_n) |=> (s1_op == $past(s1_op)))
        else $error("a_r4_continue");

    // R6: linear advance steps the low bits by one, upper bits fixed
    a_r6_linear: assert property (@(posedge clk) disable iff (rst)
        (adv && load_n && !burst_ilv) |=>
            ((s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1) &&
             (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]))))
        else $error("a_r6_linear");

    // R7: without an accepted cycle all state holds
    a_r7_freeze: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(s1_addr) && $stable(s1_op) && $stable(dout) && $stable(q_live)))
        else $error("a_r7_freeze");

    // R9: outputs are released the cycle after a sleep request
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !dout_en)
        else $error("a_r9_quiet");

endmodule

bind nwsram_top nwsram_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .load_n    (load_n),
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .sel_c_n   (sel_c_n),
    .burst_ilv (burst_ilv),
    .sleep     (sleep),
    .dout_en   (dout_en),
    .q_live    (q_live),
    .s1_op     (s1_op),
    .s1_addr   (s1_addr),
    .dout      (dout)
);

// File: tb/sim_nwsram_top.sv
module sim_nwsram_top;

    localparam int CLK_PERIOD = 10;
    localparam int LW    = 9;
    localparam int NL    = 4;
    localparam int AW    = 6;
    localparam int DW    = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          suspend = 1'b0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b1;
    logic          sel_c_n = 1'b0;
    logic          load_n = 1'b0;
    logic          rd_nwr = 1'b1;
    logic [NL-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic          burst_ilv = 1'b0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    nwsram_top #(.LANES(NL), .LANE_W(LW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .suspend(suspend),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .load_n(load_n), .rd_nwr(rd_nwr), .bw_n(bw_n), .addr(addr),
        .burst_ilv(burst_ilv), .oe_n(oe_n), .sleep(sleep),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string tag    = "R11";

    // reference model state (op codes: 0 deselect, 1 read, 2 write)
    logic [DW-1:0] ref_mem [DEPTH];
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    int            m_last = 0;
    logic          h1 = 1'b0, h2 = 1'b0;
    logic [DW-1:0] dq0 = '0, dq1 = '0;
    logic          e0_live = 1'b0, e1_live = 1'b0, o_live = 1'b0;
    logic [DW-1:0] e0_data = '0, e1_data = '0, o_data = '0;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return DW'({$urandom(), $urandom()});
    endfunction

    // One clock: inputs already set after a falling edge; wd is this command's write data.
    task automatic tick(input logic [DW-1:0] wd);
        logic          acc;
        logic          sel;
        int            op;
        logic [AW-1:0] ea;
        logic          exp_en;
        din = dq1;
        @(posedge clk);
        acc = !suspend && !h1 && !h2;
        if (acc) begin
            sel = !sel_a_n && sel_b && !sel_c_n;
            if (!load_n) begin
                op     = sel ? (rd_nwr ? 1 : 2) : 0;
                ea     = addr;
                m_base = addr;
                m_beat = 2'd0;
            end else begin
                m_beat = m_beat + 2'd1;
                op     = m_last;
                ea     = {m_base[AW-1:2], burst_ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat)};
            end
            m_last = op;
            if (op == 2) begin
                for (int l = 0; l < NL; l++)
                    if (!bw_n[l]) ref_mem[ea][l*LW +: LW] = wd[l*LW +: LW];
            end
            o_live  = e1_live;  o_data  = e1_data;
            e1_live = e0_live;  e1_data = e0_data;
            e0_live = (op == 1); e0_data = ref_mem[ea];
            dq1 = dq0;
            dq0 = wd;
        end
        h2 = h1;
        h1 = sleep;
        @(negedge clk);
        exp_en = o_live && !oe_n && !h1 && !h2;
        chk(tag, DW'(dout_en), DW'(exp_en));
        if (exp_en) chk(tag, dout, o_data);
    endtask

    task automatic cmd(input logic ln, input logic rw, input logic [NL-1:0] bw,
                       input logic [AW-1:0] a, input logic [DW-1:0] wd);
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        load_n = ln; rd_nwr = rw; bw_n = bw; addr = a;
        tick(wd);
    endtask

    task automatic desel(input int n);
        for (int i = 0; i < n; i++) begin
            sel_a_n = 1'b1; load_n = 1'b0;
            tick(rnd_word());
        end
    endtask

    task automatic rnd_cmd(input int p_susp, input int p_oe, input int p_sleep);
        load_n = (($urandom() % 3) == 0);
        if (!load_n && (($urandom() % 4) == 0)) burst_ilv = ~burst_ilv;
        if (($urandom() % 7) == 0) {sel_a_n, sel_b, sel_c_n} = 3'($urandom());
        else {sel_a_n, sel_b, sel_c_n} = 3'b010;
        rd_nwr  = $urandom() % 2;
        bw_n    = (($urandom() % 3) == 0) ? NL'($urandom()) : '0;
        addr    = AW'($urandom());
        suspend = (int'($urandom() % 100) < p_susp);
        oe_n    = (int'($urandom() % 100) < p_oe);
        if (int'($urandom() % 100) < p_sleep) sleep = ~sleep;
        tick(rnd_word());
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R11: outputs disabled during reset
        tag = "R11";
        chk(tag, DW'(dout_en), '0);
        rst = 1'b0;
        // R11: advance straight after reset continues a deselect
        load_n = 1'b1; sel_a_n = 1'b0;
        for (int i = 0; i < 3; i++) tick(rnd_word());
        desel(2);

        // R3 / R6: fill every word with linear write bursts
        tag = "R3"; burst_ilv = 1'b0;
        for (int k = 0; k < DEPTH/4; k++)
            for (int b = 0; b < 4; b++) cmd(b != 0, 1'b0, '0, AW'(k*4), rnd_word());
        desel(3);

        // R5 / R2: interleaved read bursts from every start offset
        tag = "R5"; burst_ilv = 1'b1;
        for (int k = 0; k < DEPTH/4; k++)
            for (int b = 0; b < 4; b++) cmd(b != 0, 1'b1, '0, AW'(k*4 + (k % 4)), '0);
        desel(3);

        // R6: linear read bursts, wrap within the group of four
        tag = "R6"; burst_ilv = 1'b0;
        for (int k = 0; k < DEPTH/4; k++)
            for (int b = 0; b < 4; b++) cmd(b != 0, 1'b1, '0, AW'(k*4 + ((k + 1) % 4)), '0);
        desel(3);

        // R3: every lane pattern including full abort, read straight back
        tag = "R3";
        for (int p = 0; p < 16; p++) begin
            cmd(1'b0, 1'b0, NL'(p), AW'(p), rnd_word());
            cmd(1'b0, 1'b1, '1, AW'(p), '0);
        end
        desel(3);

        // R10: back-to-back write/read over a four-word window
        tag = "R10";
        for (int i = 0; i < 400; i++)
            cmd(1'b0, i[0], NL'($urandom()), AW'($urandom() % 4), rnd_word());
        desel(3);

        // R1: all select combinations on loads and their continuations
        tag = "R1";
        for (int c = 0; c < 8; c++) begin
            {sel_a_n, sel_b, sel_c_n} = 3'(c);
            load_n = 1'b0; rd_nwr = 1'b1; addr = AW'(c * 5);
            tick('0);
            load_n = 1'b1;
            tick('0);
            tick('0);
        end
        desel(3);

        // R4: read burst, deselect continuation, write burst continuation
        tag = "R4";
        cmd(1'b0, 1'b1, '0, 6'd9, '0);
        cmd(1'b1, 1'b0, '0, 6'd0, '0);
        cmd(1'b1, 1'b0, '0, 6'd0, '0);
        desel(1);
        cmd(1'b1, 1'b1, '0, 6'd0, '0);
        cmd(1'b1, 1'b1, '0, 6'd0, '0);
        cmd(1'b0, 1'b0, 4'b0101, 6'd22, rnd_word());
        cmd(1'b1, 1'b1, 4'b1010, 6'd0, rnd_word());
        cmd(1'b1, 1'b1, 4'b0000, 6'd0, rnd_word());
        cmd(1'b0, 1'b1, '0, 6'd20, '0);
        for (int b = 0; b < 3; b++) cmd(1'b1, 1'b0, '1, 6'd0, '0);
        desel(3);

        // R7: random traffic with clock hold
        tag = "R7";
        for (int i = 0; i < 600; i++) rnd_cmd(35, 0, 0);
        suspend = 1'b0;
        desel(3);

        // R8: random traffic with output enable toggling
        tag = "R8";
        for (int i = 0; i < 600; i++) rnd_cmd(0, 40, 0);
        oe_n = 1'b0;
        desel(3);

        // R9: directed sleep during a read burst, then random sleep
        tag = "R9";
        cmd(1'b0, 1'b1, '0, 6'd33, '0);
        sleep = 1'b1;
        cmd(1'b1, 1'b1, '0, 6'd0, '0);
        for (int i = 0; i < 5; i++) cmd(1'b0, 1'b0, '0, AW'(i), rnd_word());
        sleep = 1'b0;
        for (int i = 0; i < 6; i++) cmd(1'b1, 1'b1, '0, 6'd0, '0);
        for (int i = 0; i < 800; i++) rnd_cmd(0, 0, 8);
        sleep = 1'b0;
        desel(4);

        // R2: mixed random traffic with every knob
        tag = "R2";
        for (int i = 0; i < 2000; i++) rnd_cmd(15, 15, 3);
        suspend = 1'b0; oe_n = 1'b0; sleep = 1'b0;
        desel(4);

        finish_run();
    end

endmodule